// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block reads a keyboard built as a grid of drive rows and sense columns. The sense columns are pulled down, so a column reads high only when a driven row meets a closed key. The scanner sits idle with its rows at resting levels until a column goes high. It then drives the rows one at a time. Each row gets a slot of `ROW_TICKS` oscillator periods, and the columns are sampled at the end of each slot.

A press counts only if two consecutive scans give the same key image. When they match, the image is copied into the key buffer and the active-low request line falls 615 oscillator periods after the scan began. If the two images differ while a key is still down, the whole attempt is repeated. After the host signals that it has read the buffer, the request clears and a new attempt begins. This continues until every key is released.

Two control inputs shape the resting row levels. A sleep code leaves only some rows high, and a press on one of those rows raises a wake request so the oscillator restarts. A segment selection takes the first one or two rows away for other use; those rows stay low and their key bits read as zero.

Top module: `kscan_matrix`

## Requirements
- R1: While `rst_n` is low, only the last row (`rows[ROWS-1]`) is high, `key_data` is all zero, `req_n` is high and `wake_req` is low.
- R2: In idle with `sleep_code` 00 and `seg_sel` 00, every row is driven high.
- R3: In idle, `sleep_code` 01 leaves only the last row high, 10 leaves the last two rows high, and 11 leaves every row except the first high.
- R4: `seg_sel` 01 holds row 1 (`rows[0]`) low and forces key bits 0..4 to read 0. `seg_sel` 10 or 11 holds rows 1 and 2 low and forces key bits 0..9 to read 0, including bits that were latched before the selection changed.
- R5: For a key held steadily, `req_n` falls on the 615th oscillator tick after the scan starts. `key_data` bit `r*COLS+c` is then 1 exactly for each pressed key at row index r and column index c.
- R6: If the two scans of an attempt differ while a key is still pressed, the attempt repeats, so confirmation comes on tick 1230.
- R7: A press released before the second scan of an attempt samples it produces no request.
- R8: While `ce` is high, `req_n` is high.
- R9: A `rd_done` pulse while a request is pending clears `req_n` at once. A key still held raises a new request 615 ticks later; once all keys are released, no further request is raised.
- R10: With a nonzero sleep code, a press on a row that is held high raises `wake_req` and leads to a normal request without changing the sleep row levels. A press on a row held low is ignored.
- R11: During each scan pass, row slots run from row 1 to the last row, `ROW_TICKS` ticks each, with only the row of the current slot driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator period |
| cols | input | COLS | Pulled-down sense column inputs |
| sleep_code | input | 2 | 00 normal, other codes select sleep row levels |
| seg_sel | input | 2 | 00 all rows scan, 01 row 1 for segments, 1x rows 1 and 2 for segments |
| ce | input | 1 | Host transfer active, forces the request line high |
| rd_done | input | 1 | Pulse: host has read the key buffer |
| rows | output | ROWS | Row drive levels |
| key_data | output | ROWS*COLS | Confirmed key buffer, bit r*COLS+c |
| req_n | output | 1 | Active-low key read request |
| wake_req | output | 1 | Asks the oscillator to run while in sleep |

## Verification
The hardest case to reach from the ports is a pair of scans that disagree while a key is still held. The two passes run back to back inside one attempt, so the key pattern has to change after the row being changed was sampled in the first pass and before that same row is sampled in the second. The bench counts oscillator ticks from the scan start and swaps the pressed key at tick 400, which falls between those two samples. It then expects the request at tick 1230 and the data of the second key only.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_SCAN = 2'd1,
    KS_HOLD = 2'd2
  } ks_state_t;
endpackage

// File: rtl/kscan_timer.sv
module kscan_timer #(
  parameter int ROWS      = 6,
  parameter int ROW_TICKS = 48,
  parameter int REQ_TICKS = 615,
  localparam int CW = $clog2(REQ_TICKS),
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  output logic [RW-1:0] row_idx,
  output logic          pass,
  output logic          in_scan,
  output logic          slot_end,
  output logic          decide
);
  localparam int SCAN_TICKS = ROWS * ROW_TICKS;

  logic [CW-1:0] cnt;
  logic [CW-1:0] pos;
  logic [CW-1:0] phase;

  function automatic logic [CW-1:0] pos_in_pass(logic [CW-1:0] c);
    return (c >= CW'(SCAN_TICKS)) ? c - CW'(SCAN_TICKS) : c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= (cnt == CW'(REQ_TICKS - 1)) ? '0 : cnt + 1'b1;
  end

  assign pos      = pos_in_pass(cnt);
  assign phase    = pos % CW'(ROW_TICKS);
  assign row_idx  = RW'(pos / CW'(ROW_TICKS));
  assign pass     = (cnt >= CW'(SCAN_TICKS));
  assign in_scan  = run && (cnt < CW'(2 * SCAN_TICKS));
  assign slot_end = tick && in_scan && (phase == CW'(ROW_TICKS - 1));
  assign decide   = tick && run && (cnt == CW'(REQ_TICKS - 1));
endmodule

// File: rtl/kscan_capture.sv
module kscan_capture #(
  parameter int ROWS = 6,
  parameter int COLS = 5,
  localparam int KEYS = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slot_end,
  input  logic            pass,
  input  logic [RW-1:0]   row_idx,
  input  logic [ROWS-1:0] en_mask,
  input  logic [COLS-1:0] cols,
  output logic [KEYS-1:0] scan_a,
  output logic [KEYS-1:0] scan_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_a <= '0;
      scan_b <= '0;
    end else if (slot_end) begin
      for (int r = 0; r < ROWS; r++) begin
        if (row_idx == RW'(r)) begin
          if (pass) scan_b[r*COLS +: COLS] <= cols & {COLS{en_mask[r]}};
          else      scan_a[r*COLS +: COLS] <= cols & {COLS{en_mask[r]}};
        end
      end
    end
  end
endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
#(
  parameter int KEYS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            col_any,
  input  logic            decide,
  input  logic            rd_done,
  input  logic [KEYS-1:0] scan_a,
  input  logic [KEYS-1:0] scan_b,
  output ks_state_t       state,
  output logic            req_pend,
  output logic [KEYS-1:0] keybuf
);
  logic images_match;
  logic still_pressed;

  assign images_match  = (scan_a == scan_b);
  assign still_pressed = |scan_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= KS_IDLE;
      req_pend <= 1'b0;
      keybuf   <= '0;
    end else begin
      unique case (state)
        KS_IDLE: if (col_any) state <= KS_SCAN;
        KS_SCAN: begin
          if (decide) begin
            if (!still_pressed) begin
              state <= KS_IDLE;
            end else if (images_match) begin
              state    <= KS_HOLD;
              keybuf   <= scan_b;
              req_pend <= 1'b1;
            end
          end
        end
        KS_HOLD: begin
          if (rd_done) begin
            req_pend <= 1'b0;
            state    <= KS_SCAN;
          end
        end
        default: state <= KS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kscan_matrix.sv
module kscan_matrix
  import kscan_pkg::*;
#(
  parameter int ROWS      = 6,
  parameter int COLS      = 5,
  parameter int ROW_TICKS = 48,
  parameter int REQ_TICKS = 615,
  localparam int KEYS = ROWS * COLS,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            osc_tick,
  input  logic [COLS-1:0] cols,
  input  logic [1:0]      sleep_code,
  input  logic [1:0]      seg_sel,
  input  logic            ce,
  input  logic            rd_done,
  output logic [ROWS-1:0] rows,
  output logic [KEYS-1:0] key_data,
  output logic            req_n,
  output logic            wake_req
);
  function automatic logic [ROWS-1:0] row_enable(logic [1:0] slp, logic [1:0] ks);
    logic [ROWS-1:0] m;
    case (slp)
      2'b00:   m = '1;
      2'b01:   m = ROWS'(1) << (ROWS - 1);
      2'b10:   m = ROWS'(3) << (ROWS - 2);
      default: m = ~ROWS'(1);
    endcase
    if (ks == 2'b01) m[0] = 1'b0;
    else if (ks[1])  m[1:0] = 2'b00;
    return m;
  endfunction

  function automatic logic [KEYS-1:0] key_keep(logic [1:0] ks);
    logic [KEYS-1:0] k;
    k = '1;
    if (ks == 2'b01) k[COLS-1:0] = '0;
    else if (ks[1])  k[2*COLS-1:0] = '0;
    return k;
  endfunction

  ks_state_t       state;
  logic            req_pend;
  logic [KEYS-1:0] keybuf;
  logic [KEYS-1:0] scan_a, scan_b;
  logic [RW-1:0]   row_idx;
  logic            pass, in_scan, slot_end, decide;
  logic [ROWS-1:0] en_mask;
  logic            scan_active;
  logic            col_any;

  assign en_mask     = row_enable(sleep_code, seg_sel);
  assign scan_active = (state == KS_SCAN);
  assign col_any     = |cols;

  kscan_timer #(.ROWS(ROWS), .ROW_TICKS(ROW_TICKS), .REQ_TICKS(REQ_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(scan_active), .tick(osc_tick),
    .row_idx(row_idx), .pass(pass), .in_scan(in_scan),
    .slot_end(slot_end), .decide(decide)
  );

  kscan_capture #(.ROWS(ROWS), .COLS(COLS)) u_cap (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .pass(pass),
    .row_idx(row_idx), .en_mask(en_mask), .cols(cols),
    .scan_a(scan_a), .scan_b(scan_b)
  );

  kscan_ctrl #(.KEYS(KEYS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .col_any(col_any), .decide(decide),
    .rd_done(rd_done), .scan_a(scan_a), .scan_b(scan_b),
    .state(state), .req_pend(req_pend), .keybuf(keybuf)
  );

  always_comb begin
    if (!rst_n)           rows = ROWS'(1) << (ROWS - 1);
    else if (scan_active) rows = in_scan ? (en_mask & (ROWS'(1) << row_idx)) : '0;
    else                  rows = en_mask;
  end

  assign key_data = keybuf & key_keep(seg_sel);
  assign req_n    = ~req_pend | ce;
  assign wake_req = rst_n && (sleep_code != 2'b00) && ((state != KS_IDLE) || col_any);
endmodule

// File: rtl/kscan_chk.sv
module kscan_chk #(
  parameter int ROWS = 6,
  parameter int COLS = 5,
  localparam int KEYS = ROWS * COLS
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ROWS-1:0] rows,
  input logic [KEYS-1:0] key_data,
  input logic            req_n,
  input logic            ce,
  input logic            rd_done,
  input logic [1:0]      sleep_code,
  input logic [1:0]      seg_sel,
  input logic            wake_req,
  input logic            scan_active,
  input logic            req_pend,
  input logic            decide
);
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_state: assert (rows == (ROWS'(1) << (ROWS - 1)) && req_n && key_data == '0 && !wake_req)
        else $error("reset state violated");
    end
  end

  a_r8_ce_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    ce |-> req_n) else $error("req_n low while ce high");

  a_r11_single_row: assert property (@(posedge clk) disable iff (!rst_n)
    scan_active |-> $onehot0(rows)) else $error("more than one row driven in scan");

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pend && rd_done) |=> !req_pend) else $error("read did not clear request");

  a_r5_req_on_decide: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_pend) |-> $past(decide)) else $error("request rose outside decision tick");

  a_r10_wake_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_code != 2'b00 && req_pend) |-> wake_req) else $error("no wake request during sleep hold");

  a_r4_seg_rows_low: assert property (@(posedge clk) disable iff (!rst_n)
    seg_sel[1] |-> (rows[1:0] == 2'b00)) else $error("segment rows driven");
endmodule

bind kscan_matrix kscan_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .rows(rows), .key_data(key_data), .req_n(req_n),
  .ce(ce), .rd_done(rd_done), .sleep_code(sleep_code), .seg_sel(seg_sel),
  .wake_req(wake_req), .scan_active(scan_active), .req_pend(req_pend),
  .decide(decide)
);

// File: tb/sim_kscan_matrix.sv
`timescale 1ns/1ps
module sim_kscan_matrix;
  localparam int ROWS = 6;
  localparam int COLS = 5;
  localparam int KEYS = 30;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            osc_tick = 1'b0;
  logic [COLS-1:0] cols;
  logic [1:0]      sleep_code = 2'b00;
  logic [1:0]      seg_sel = 2'b00;
  logic            ce = 1'b0;
  logic            rd_done = 1'b0;
  logic [ROWS-1:0] rows;
  logic [KEYS-1:0] key_data;
  logic            req_n;
  logic            wake_req;
  logic [KEYS-1:0] pressed = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;
  always @(negedge clk) osc_tick <= ~osc_tick;

  always_comb begin
    cols = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        if (rows[r] && pressed[r*COLS + c]) cols[c] = 1'b1;
  end

  kscan_matrix u0 (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cols(cols),
    .sleep_code(sleep_code), .seg_sel(seg_sel), .ce(ce), .rd_done(rd_done),
    .rows(rows), .key_data(key_data), .req_n(req_n), .wake_req(wake_req)
  );

  function automatic logic [ROWS-1:0] exp_rows(logic [1:0] slp, logic [1:0] ks);
    logic [ROWS-1:0] v;
    v = (slp == 2'b01) ? 6'b100000 : (slp == 2'b10) ? 6'b110000 :
        (slp == 2'b11) ? 6'b111110 : 6'b111111;
    if (ks == 2'b01) v = v & 6'b111110;
    if (ks[1])       v = v & 6'b111100;
    return v;
  endfunction

  function automatic logic [KEYS-1:0] exp_keep(logic [1:0] ks);
    if (ks == 2'b00) return 30'h3fffffff;
    if (ks == 2'b01) return 30'h3fffffe0;
    return 30'h3ffffc00;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic wait_ticks(input int n, output int lows);
    int k;
    k = 0; lows = 0;
    while (k < n) begin
      bit t;
      @(posedge clk); t = osc_tick; #1;
      if (t) k++;
      if (!req_n) lows++;
    end
  endtask

  task automatic time_req(output int n);
    n = 0;
    for (int g = 0; g < 6000; g++) begin
      bit t;
      @(posedge clk); t = osc_tick; #1;
      if (t) n++;
      if (!req_n) return;
    end
    n = 99999;
  endtask

  task automatic start_edge();
    @(posedge clk); #1;
  endtask

  task automatic host_read();
    @(negedge clk); rd_done = 1'b1;
    @(posedge clk); #1; rd_done = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
      report();
    end
  end

  initial begin
    int n, lows, n2;
    void'($urandom(32'h00c0ffee));

    // R1: state held in reset
    repeat (3) @(posedge clk);
    #1;
    check(rows == 6'b100000, "R1", "rows in reset", rows, 6'b100000);
    check(key_data == '0, "R1", "key_data in reset", key_data, 0);
    check(req_n == 1'b1 && wake_req == 1'b0, "R1", "req_n/wake in reset", {req_n, wake_req}, 2'b10);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R2: normal idle drive
    check(rows == exp_rows(2'b00, 2'b00), "R2", "idle rows", rows, exp_rows(2'b00, 2'b00));

    // R5 / R11: steady press, row slot walk and timing
    @(negedge clk); pressed = 30'd1 << 13;
    start_edge();
    wait_ticks(24, lows);
    check(rows == 6'b000001, "R11", "rows at tick 24", rows, 6'b000001);
    wait_ticks(76, lows);
    check(rows == 6'b000100, "R11", "rows at tick 100", rows, 6'b000100);
    time_req(n);
    check(100 + n == 615, "R5", "ticks to request", 100 + n, 615);
    check(key_data == (30'd1 << 13), "R5", "key_data row3 col4", key_data, 30'd1 << 13);

    // R8: chip enable blocks request
    @(negedge clk); ce = 1'b1; #1;
    check(req_n == 1'b1, "R8", "req_n with ce high", req_n, 1);
    @(negedge clk); ce = 1'b0; #1;
    check(req_n == 1'b0, "R8", "req_n after ce low", req_n, 0);

    // R9: read clears, held key re-requests
    host_read();
    check(req_n == 1'b1, "R9", "req_n after read", req_n, 1);
    time_req(n);
    check(n == 615, "R9", "ticks to second request", n, 615);
    host_read();
    @(negedge clk); pressed = '0;
    wait_ticks(700, lows);
    check(lows == 0, "R9", "request after release", lows, 0);
    check(rows == 6'b111111 && wake_req == 1'b0, "R9", "back to idle", rows, 6'b111111);

    // R6: scans disagree with key held
    @(negedge clk); pressed = 30'd1;
    start_edge();
    wait_ticks(400, lows);
    pressed = 30'd1 << 29;
    time_req(n);
    check(400 + n == 1230, "R6", "ticks to request after mismatch", 400 + n, 1230);
    check(key_data == (30'd1 << 29), "R6", "key_data after mismatch", key_data, 30'd1 << 29);
    host_read();
    @(negedge clk); pressed = '0;
    wait_ticks(700, lows);

    // R7: short press never reported
    @(negedge clk); pressed = 30'd1 << 7;
    start_edge();
    wait_ticks(100, lows);
    pressed = '0;
    wait_ticks(1300, lows);
    check(lows == 0, "R7", "request cycles for short press", lows, 0);

    // R4: segment rows
    @(negedge clk); seg_sel = 2'b01; #1;
    check(rows == exp_rows(2'b00, 2'b01), "R4", "rows seg 01", rows, exp_rows(2'b00, 2'b01));
    @(negedge clk); seg_sel = 2'b10; #1;
    check(rows == exp_rows(2'b00, 2'b10), "R4", "rows seg 10", rows, exp_rows(2'b00, 2'b10));
    @(negedge clk); seg_sel = 2'b00; pressed = (30'd1 << 2) | (30'd1 << 20);
    start_edge();
    time_req(n);
    check(n == 615, "R5", "ticks two keys", n, 615);
    check(key_data == ((30'd1 << 2) | (30'd1 << 20)), "R5", "key_data two keys", key_data, (30'd1 << 2) | (30'd1 << 20));
    @(negedge clk); seg_sel = 2'b10; #1;
    check(key_data == (30'd1 << 20), "R4", "latched low bits masked", key_data, 30'd1 << 20);
    host_read();
    @(negedge clk); pressed = '0; seg_sel = 2'b00;
    wait_ticks(700, lows);

    // R3: sleep row levels
    for (int s = 1; s < 4; s++) begin
      @(negedge clk); sleep_code = 2'(s); #1;
      check(rows == exp_rows(2'(s), 2'b00), "R3", "sleep rows", rows, exp_rows(2'(s), 2'b00));
    end

    // R10: wake on held-high row only
    @(negedge clk); sleep_code = 2'b01; pressed = 30'd1 << 12;
    @(posedge clk); #1;
    check(wake_req == 1'b0, "R10", "wake for low row", wake_req, 0);
    wait_ticks(700, lows);
    check(lows == 0, "R10", "request for low row", lows, 0);
    @(negedge clk); pressed = 30'd1 << 27; #1;
    check(wake_req == 1'b1, "R10", "wake for high row", wake_req, 1);
    start_edge();
    time_req(n);
    check(n == 615, "R10", "ticks in sleep", n, 615);
    check(key_data == (30'd1 << 27), "R10", "key_data in sleep", key_data, 30'd1 << 27);
    check(rows == 6'b100000, "R10", "sleep rows kept", rows, 6'b100000);
    host_read();
    @(negedge clk); pressed = '0;
    wait_ticks(700, lows);
    check(wake_req == 1'b0 && rows == 6'b100000, "R10", "sleep idle after release", {wake_req, rows}, 7'b0100000);
    @(negedge clk); sleep_code = 2'b00;

    // Random key sets over segment selections (R4, R5)
    for (int it = 0; it < 6; it++) begin
      logic [1:0] ks;
      logic [KEYS-1:0] expd;
      int k;
      ks = 2'($urandom_range(0, 2));
      k  = int'($urandom_range(1, 3));
      @(negedge clk);
      seg_sel = ks;
      pressed = 30'd1 << $urandom_range(10, 29);
      for (int j = 1; j < k; j++) pressed = pressed | (30'd1 << $urandom_range(0, 29));
      expd = pressed & exp_keep(ks);
      start_edge();
      time_req(n2);
      check(n2 == 615, "R5", "random ticks", n2, 615);
      check(key_data == expd, "R4", "random key_data", key_data, expd);
      host_read();
      @(negedge clk); pressed = '0;
      wait_ticks(700, lows);
      check(lows == 0, "R9", "random no request after release", lows, 0);
    end
    @(negedge clk); seg_sel = 2'b00;

    // R1: reset while a request is pending
    @(negedge clk); pressed = 30'd1 << 14;
    start_edge();
    time_req(n);
    @(negedge clk); rst_n = 1'b0; #1;
    check(key_data == '0 && req_n == 1'b1, "R1", "mid reset key/req", {req_n, key_data}, 31'h40000000);
    check(rows == 6'b100000, "R1", "mid reset rows", rows, 6'b100000);
    pressed = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    report();
  end
endmodule